// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block produces every strobe and port value of a multiplexed external memory bus for a small 8-bit controller core. It runs directly from the oscillator clock. A 12-state machine cycle is split into two 6-state slots. In each slot the sequencer can pulse the address-latch strobe and then the program-store read strobe. The low address byte and the data share one 8-bit port with an output enable. The upper address byte has a port of its own.

The core hands over one request per machine cycle. The request is a code fetch, an external data read or an external data write, and a data access uses either a 16-bit address or an 8-bit address. For an 8-bit address, the high port shows the internal port-2 register instead of an address byte. A fetch reads two consecutive bytes, one in each slot. A data access takes a whole machine cycle. In that cycle one address-latch pulse and both program-store pulses are replaced by a single long read or write strobe. Phases are numbered 0 to 11 from the first oscillator period of a machine cycle. Phase 0 follows the release of reset directly.

Top module: `ext_bus_sequencer`

## Requirements
- R1: While rst_i is high, ale_o is low, psen_n_o, rd_n_o and wr_n_o are high, ad_oe_o, ready_o and done_o are low, and no request is taken.
- R2: In idle and fetch cycles ale_o is high in phases 0, 1, 6 and 7 and low in all other phases, which gives two pulses per 12-state cycle, each two states wide.
- R3: In a fetch cycle psen_n_o is low in phases 3-5 and 9-11 and high otherwise. In idle cycles psen_n_o stays high.
- R4: A fetch of address A drives A[7:0] on ad_o with ad_oe_o high in phases 0-2, and (A+1)[7:0] in phases 6-8, wrapping at 16 bits. ahi_o shows the high byte of A in phases 0-5 and of A+1 in phases 6-11. ad_oe_o is low in phases 3-5 and 9-11.
- R5: A fetch samples ad_i on the clock edge that ends phase 5, placing it in done_data_o[7:0], and on the edge that ends phase 11, placing it in done_data_o[15:8].
- R6: In a data cycle ale_o is high only in phases 0 and 1, and psen_n_o stays high for the whole cycle.
- R7: Request codes: 1 fetch, 2 read with 16-bit address, 3 read with 8-bit address, 4 write with 16-bit address, 5 write with 8-bit address. A read drives rd_n_o low in phases 5-10 and a write drives wr_n_o low in phases 5-10. The strobe not used by the access stays high.
- R8: For codes 2 and 4, ahi_o carries the high address byte for the whole cycle. For codes 3 and 5, and in idle cycles, it carries p2_reg_i.
- R9: A data cycle drives the low address byte with ad_oe_o high in phases 0-2. A write then drives the write byte with ad_oe_o high in phases 3-11. A read holds ad_oe_o low in phases 3-11.
- R10: A read samples ad_i on the edge that ends phase 10 and reports {8'h00, byte} on done_data_o. A write reports 16'h0000.
- R11: ready_o is high only in phase 11. A request present there (req_i high, code 1-5) is taken on that edge and run in the next cycle. done_o is high for exactly phase 0 of the cycle after the request ran. req_i low, or codes 0, 6 and 7, give an idle cycle with no done_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock; one state per period |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request valid, taken when ready_o is high |
| req_op_i | input | 3 | Request code (see R7) |
| req_addr_i | input | 16 | Request address |
| req_wdata_i | input | 8 | Byte to write |
| p2_reg_i | input | 8 | Port-2 register value shown for 8-bit-address cycles |
| ad_i | input | 8 | Shared low address/data port, input side |
| ready_o | output | 1 | High in the last state of a machine cycle |
| done_o | output | 1 | One-state completion pulse |
| done_data_o | output | 16 | Fetched bytes or read byte |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_n_o | output | 1 | Program read strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| ad_o | output | 8 | Shared low address/data port, output side |
| ad_oe_o | output | 1 | Output enable of the shared port |
| ahi_o | output | 8 | High address port |

## Verification
Two events share one clock edge: the edge that ends phase 11. On that edge the second fetched byte is captured, and the next request is accepted while the finished cycle's result is assembled. The same phase also holds the write data after the write strobe. The bench runs back-to-back requests in which every code follows every other code, with addresses whose low byte carries into the high byte on the second fetch slot. It then checks that done_o in phase 0 carries the bytes of the cycle that just finished. On the shared port, decoy values are driven in every phase except the sampling phase, so a capture one state early or late returns the wrong bytes.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  localparam int DATA_W       = 8;
  localparam int ADDR_W       = 16;
  localparam int CYC_STATES   = 12;
  localparam int SLOT_STATES  = 6;
  localparam int SLOTS        = CYC_STATES / SLOT_STATES;
  localparam int ALE_STATES   = 2;
  localparam int PSEN_LAG     = 1;
  localparam int PSEN_STATES  = 3;
  localparam int XS_LAG       = 3;
  localparam int XS_STATES    = 6;
  localparam int PH_W         = $clog2(CYC_STATES);
  localparam int CAP_W        = DATA_W * SLOTS;
  localparam int PSEN_FIRST   = ALE_STATES + PSEN_LAG - 1;
  localparam int XS_FIRST     = ALE_STATES + XS_LAG;
  localparam int XS_LAST      = XS_FIRST + XS_STATES - 1;

  typedef logic [PH_W-1:0] phase_t;

  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_FETCH     = 3'd1,
    OP_RD_WIDE   = 3'd2,
    OP_RD_NARROW = 3'd3,
    OP_WR_WIDE   = 3'd4,
    OP_WR_NARROW = 3'd5
  } bus_op_e;

  function automatic bus_op_e decode_op(input logic req, input logic [2:0] code);
    if (!req || code > 3'd5) return OP_IDLE;
    return bus_op_e'(code);
  endfunction

  function automatic logic op_is_fetch(input bus_op_e op);
    return op == OP_FETCH;
  endfunction

  function automatic logic op_is_read(input bus_op_e op);
    return (op == OP_RD_WIDE) || (op == OP_RD_NARROW);
  endfunction

  function automatic logic op_is_write(input bus_op_e op);
    return (op == OP_WR_WIDE) || (op == OP_WR_NARROW);
  endfunction

  function automatic logic op_is_wide(input bus_op_e op);
    return (op == OP_RD_WIDE) || (op == OP_WR_WIDE);
  endfunction

  function automatic phase_t slot_offset(input phase_t ph);
    return phase_t'(int'(ph) % SLOT_STATES);
  endfunction

  function automatic phase_t slot_index(input phase_t ph);
    return phase_t'(int'(ph) / SLOT_STATES);
  endfunction

  // Address occupies the port while ALE is high and one state after it falls.
  function automatic logic addr_window(input phase_t off);
    return int'(off) <= ALE_STATES;
  endfunction

  function automatic logic ale_window(input phase_t ph, input logic data_cycle);
    if (data_cycle) return int'(ph) < ALE_STATES;
    return int'(slot_offset(ph)) < ALE_STATES;
  endfunction

  function automatic logic psen_window(input phase_t ph);
    return (int'(slot_offset(ph)) > PSEN_FIRST) &&
           (int'(slot_offset(ph)) <= PSEN_FIRST + PSEN_STATES);
  endfunction

  function automatic logic xs_window(input phase_t ph);
    return (int'(ph) >= XS_FIRST) && (int'(ph) <= XS_LAST);
  endfunction
endpackage

// File: rtl/bus_seq_timer.sv
module bus_seq_timer
  import bus_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  output phase_t phase_o,
  output logic   cycle_end_o
);
  localparam phase_t LAST_PH = phase_t'(CYC_STATES - 1);

  phase_t phase_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                 phase_q <= '0;
    else if (phase_q == LAST_PH) phase_q <= '0;
    else                       phase_q <= phase_q + phase_t'(1);
  end

  assign phase_o     = phase_q;
  assign cycle_end_o = (phase_q == LAST_PH);
endmodule

// File: rtl/bus_seq_strobes.sv
module bus_seq_strobes
  import bus_seq_pkg::*;
(
  input  logic    rst_i,
  input  phase_t  phase_i,
  input  bus_op_e op_i,
  output logic    ale_o,
  output logic    psen_n_o,
  output logic    rd_n_o,
  output logic    wr_n_o
);
  logic data_cycle;
  assign data_cycle = op_is_read(op_i) || op_is_write(op_i);

  always_comb begin
    ale_o    = 1'b0;
    psen_n_o = 1'b1;
    rd_n_o   = 1'b1;
    wr_n_o   = 1'b1;
    if (!rst_i) begin
      ale_o    = ale_window(phase_i, data_cycle);
      psen_n_o = !(op_is_fetch(op_i) && psen_window(phase_i));
      rd_n_o   = !(op_is_read(op_i)  && xs_window(phase_i));
      wr_n_o   = !(op_is_write(op_i) && xs_window(phase_i));
    end
  end
endmodule

// File: rtl/bus_seq_datapath.sv
module bus_seq_datapath
  import bus_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  phase_t            phase_i,
  input  logic              cycle_end_i,
  input  logic              req_i,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] p2_i,
  input  logic [DATA_W-1:0] ad_i,
  output bus_op_e           op_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [DATA_W-1:0] ahi_o,
  output logic              done_o,
  output logic [CAP_W-1:0]  done_data_o,
  output logic              sample_o
);
  localparam phase_t RD_SAMPLE_PH = phase_t'(XS_LAST);

  bus_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] slot_addr;
  logic [DATA_W-1:0] cap_q [SLOTS];
  logic [DATA_W-1:0] cap_n [SLOTS];
  logic [SLOTS-1:0]  slot_hit;
  logic              rd_hit;
  logic [CAP_W-1:0]  result;
  logic              done_q;
  logic [CAP_W-1:0]  done_data_q;

  assign slot_addr = addr_q + ADDR_W'(slot_index(phase_i));
  assign rd_hit    = op_is_read(op_q) && (phase_i == RD_SAMPLE_PH);

  // One capture register per fetch slot; slot 0 also takes the data read byte.
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_hit[g] = op_is_fetch(op_q) &&
                         (phase_i == phase_t'(g * SLOT_STATES + SLOT_STATES - 1));
    always_comb begin
      cap_n[g] = cap_q[g];
      if (slot_hit[g] || (g == 0 && rd_hit)) cap_n[g] = ad_i;
    end
    always_ff @(posedge clk_i) begin
      if (rst_i) cap_q[g] <= '0;
      else       cap_q[g] <= cap_n[g];
    end
  end

  assign sample_o = (|slot_hit) || rd_hit;

  // The last capture lands on the same edge that closes the cycle: use cap_n.
  always_comb begin
    result = '0;
    if (op_is_fetch(op_q)) begin
      for (int g = 0; g < SLOTS; g++) result[g*DATA_W +: DATA_W] = cap_n[g];
    end else if (op_is_read(op_q)) begin
      result[DATA_W-1:0] = cap_n[0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      op_q        <= OP_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      done_q      <= 1'b0;
      done_data_q <= '0;
    end else if (cycle_end_i) begin
      op_q        <= decode_op(req_i, req_op_i);
      addr_q      <= req_addr_i;
      wdata_q     <= req_wdata_i;
      done_q      <= (op_q != OP_IDLE);
      done_data_q <= result;
    end else begin
      done_q      <= 1'b0;
    end
  end

  always_comb begin
    ad_o    = '0;
    ad_oe_o = 1'b0;
    ahi_o   = p2_i;
    if (op_is_fetch(op_q)) begin
      ahi_o = slot_addr[ADDR_W-1:DATA_W];
      if (addr_window(slot_offset(phase_i))) begin
        ad_oe_o = 1'b1;
        ad_o    = slot_addr[DATA_W-1:0];
      end
    end else if (op_is_read(op_q) || op_is_write(op_q)) begin
      if (op_is_wide(op_q)) ahi_o = addr_q[ADDR_W-1:DATA_W];
      if (addr_window(phase_i)) begin
        ad_oe_o = 1'b1;
        ad_o    = addr_q[DATA_W-1:0];
      end else if (op_is_write(op_q)) begin
        ad_oe_o = 1'b1;
        ad_o    = wdata_q;
      end
    end
  end

  assign op_o        = op_q;
  assign done_o      = done_q;
  assign done_data_o = done_data_q;
endmodule

// File: rtl/ext_bus_sequencer.sv
module ext_bus_sequencer
  import bus_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_i,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] p2_reg_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [CAP_W-1:0]  done_data_o,
  output logic              ale_o,
  output logic              psen_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [DATA_W-1:0] ahi_o
);
  phase_t  phase_w;
  logic    cycle_end_w;
  bus_op_e op_w;
  logic    sample_w;

  bus_seq_timer u_timer (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .phase_o     (phase_w),
    .cycle_end_o (cycle_end_w)
  );

  bus_seq_datapath u_dp (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .phase_i     (phase_w),
    .cycle_end_i (cycle_end_w),
    .req_i       (req_i),
    .req_op_i    (req_op_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .p2_i        (p2_reg_i),
    .ad_i        (ad_i),
    .op_o        (op_w),
    .ad_o        (ad_o),
    .ad_oe_o     (ad_oe_o),
    .ahi_o       (ahi_o),
    .done_o      (done_o),
    .done_data_o (done_data_o),
    .sample_o    (sample_w)
  );

  bus_seq_strobes u_strobes (
    .rst_i    (rst_i),
    .phase_i  (phase_w),
    .op_i     (op_w),
    .ale_o    (ale_o),
    .psen_n_o (psen_n_o),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o)
  );

  assign ready_o = cycle_end_w && !rst_i;
endmodule

// File: rtl/ext_bus_sequencer_chk.sv
module ext_bus_sequencer_chk
  import bus_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_i,
  input logic              ready_o,
  input logic              done_o,
  input logic              ale_o,
  input logic              psen_n_o,
  input logic              rd_n_o,
  input logic              wr_n_o,
  input logic [DATA_W-1:0] ad_o,
  input logic              ad_oe_o,
  input logic              sample_w
);
  always @(posedge clk_i) begin
    if (rst_i) begin
      assert_reset_quiet_R1: assert (!ale_o && psen_n_o && rd_n_o && wr_n_o &&
                                     !ad_oe_o && !ready_o);
    end
  end

  assert_ale_two_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ale_o) |=> ale_o);

  assert_ale_end_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (ale_o && $past(ale_o)) |=> !ale_o);

  assert_psen_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(psen_n_o) |=> !psen_n_o);

  assert_psen_vs_data_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !psen_n_o |-> (rd_n_o && wr_n_o));

  assert_rd_wr_excl_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !(!rd_n_o && !wr_n_o));

  assert_read_released_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_n_o |-> !ad_oe_o);

  assert_wdata_stable_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (!wr_n_o && $past(!wr_n_o)) |-> $stable(ad_o));

  assert_sample_released_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    sample_w |-> !ad_oe_o);

  assert_done_single_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  assert_ready_single_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    ready_o |=> !ready_o);

  assert_done_after_ready_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> $past(ready_o));
endmodule

bind ext_bus_sequencer ext_bus_sequencer_chk u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .ready_o  (ready_o),
  .done_o   (done_o),
  .ale_o    (ale_o),
  .psen_n_o (psen_n_o),
  .rd_n_o   (rd_n_o),
  .wr_n_o   (wr_n_o),
  .ad_o     (ad_o),
  .ad_oe_o  (ad_oe_o),
  .sample_w (sample_w)
);

// File: tb/ext_bus_sequencer_tb_top.sv
module ext_bus_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_i;
  logic        req_i;
  logic [2:0]  req_op_i;
  logic [15:0] req_addr_i;
  logic [7:0]  req_wdata_i;
  logic [7:0]  p2_reg_i;
  logic [7:0]  ad_i;
  logic        ready_o, done_o, ale_o, psen_n_o, rd_n_o, wr_n_o, ad_oe_o;
  logic [15:0] done_data_o;
  logic [7:0]  ad_o, ahi_o;

  int checks = 0;
  int errors = 0;

  // current cycle (accepted request) and previous cycle result
  int          cur_kind = 0;
  logic [15:0] cur_addr = '0;
  logic [7:0]  cur_wd = '0, cur_p2 = '0, cur_b0 = '0, cur_b1 = '0, cur_brd = '0;
  bit          prev_valid = 0;
  logic [15:0] prev_data = '0;

  always #5 clk = ~clk;

  ext_bus_sequencer dut_i (
    .clk_i(clk), .rst_i(rst_i), .req_i(req_i), .req_op_i(req_op_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .p2_reg_i(p2_reg_i),
    .ad_i(ad_i), .ready_o(ready_o), .done_o(done_o), .done_data_o(done_data_o),
    .ale_o(ale_o), .psen_n_o(psen_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ahi_o(ahi_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_cycle(input bit nreq, input logic [2:0] nop,
                           input logic [15:0] naddr, input logic [7:0] nwd,
                           input logic [7:0] np2);
    bit fetch, rd, wr, wide, data;
    logic [15:0] sa, exp_done;
    logic [7:0]  exp_ad;
    bit exp_oe;
    int off, slot;
    fetch = (cur_kind == 1);
    rd    = (cur_kind == 2) || (cur_kind == 3);
    wr    = (cur_kind == 4) || (cur_kind == 5);
    wide  = (cur_kind == 2) || (cur_kind == 4);
    data  = rd || wr;
    for (int ph = 0; ph < 12; ph++) begin
      off  = ph % 6;
      slot = ph / 6;
      sa   = cur_addr + 16'(slot);
      if (ph == 0) begin
        req_i    = 1'b0;
        p2_reg_i = cur_p2;
      end
      // decoys everywhere but the true sampling state
      if (fetch)   ad_i = (ph == 5) ? cur_b0 : (ph == 11) ? cur_b1 : ((slot == 0 ? cur_b0 : cur_b1) ^ 8'hFF);
      else if (rd) ad_i = (ph == 10) ? cur_brd : (cur_brd ^ 8'hFF);
      else         ad_i = 8'(8'h5A + ph);
      if (ph == 11) begin
        req_i = nreq; req_op_i = nop; req_addr_i = naddr; req_wdata_i = nwd;
      end
      #1;
      if (ph == 0) begin
        chk("R11", "done pulse", 32'(done_o), 32'(prev_valid));
        if (prev_valid) chk("R5/R10", "done data", 32'(done_data_o), 32'(prev_data));
      end else begin
        chk("R11", "done outside phase 0", 32'(done_o), 32'd0);
      end
      chk("R11", "ready", 32'(ready_o), 32'(ph == 11));
      if (data) chk("R6", "ale data cycle", 32'(ale_o), 32'(ph < 2));
      else      chk("R2", "ale", 32'(ale_o), 32'(off < 2));
      if (fetch) chk("R3", "psen fetch", 32'(psen_n_o), 32'(!(off >= 3)));
      else       chk("R3/R6", "psen idle", 32'(psen_n_o), 32'd1);
      chk("R7", "rd strobe", 32'(rd_n_o), 32'(!(rd && ph >= 5 && ph <= 10)));
      chk("R7", "wr strobe", 32'(wr_n_o), 32'(!(wr && ph >= 5 && ph <= 10)));
      if (fetch) begin
        exp_oe = (off < 3);
        exp_ad = sa[7:0];
        chk("R4", "fetch ahi", 32'(ahi_o), 32'(sa[15:8]));
      end else if (data) begin
        exp_oe = (ph < 3) || wr;
        exp_ad = (ph < 3) ? cur_addr[7:0] : cur_wd;
        chk("R8", "data ahi", 32'(ahi_o), 32'(wide ? cur_addr[15:8] : cur_p2));
      end else begin
        exp_oe = 1'b0;
        exp_ad = 8'h00;
        chk("R8", "idle ahi", 32'(ahi_o), 32'(cur_p2));
      end
      chk(fetch ? "R4" : "R9", "port enable", 32'(ad_oe_o), 32'(exp_oe));
      if (exp_oe) chk(fetch ? "R4" : "R9", "port value", 32'(ad_o), 32'(exp_ad));
      @(posedge clk);
      @(negedge clk);
    end
    exp_done   = fetch ? {cur_b1, cur_b0} : rd ? {8'h00, cur_brd} : 16'h0000;
    prev_valid = (cur_kind != 0);
    prev_data  = exp_done;
    cur_kind   = (nreq && nop >= 3'd1 && nop <= 3'd5) ? int'(nop) : 0;
    cur_addr   = naddr;
    cur_wd     = nwd;
    cur_p2     = np2;
    cur_b0     = naddr[7:0] ^ 8'h3C;
    cur_b1     = naddr[15:8] ^ 8'hC3;
    cur_brd    = naddr[7:0] + 8'h11;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] addrs [4];
    addrs[0] = 16'h0000; addrs[1] = 16'h00FF; addrs[2] = 16'hA55A; addrs[3] = 16'hFFFF;
    rst_i = 1'b1; req_i = 1'b1; req_op_i = 3'd1; req_addr_i = 16'h1234;
    req_wdata_i = 8'h00; p2_reg_i = 8'h00; ad_i = 8'h00;
    repeat (4) begin
      @(negedge clk); #1;
      // R1: strobes idle while reset holds, even with a request present
      chk("R1", "ale in reset", 32'(ale_o), 32'd0);
      chk("R1", "psen in reset", 32'(psen_n_o), 32'd1);
      chk("R1", "rd in reset", 32'(rd_n_o), 32'd1);
      chk("R1", "wr in reset", 32'(wr_n_o), 32'd1);
      chk("R1", "oe in reset", 32'(ad_oe_o), 32'd0);
      chk("R1", "ready in reset", 32'(ready_o), 32'd0);
      chk("R1", "done in reset", 32'(done_o), 32'd0);
    end
    @(negedge clk);
    rst_i = 1'b0;
    req_i = 1'b0;
    // every code after every other code, including carry on the second fetch slot
    for (int k = 0; k < 8; k++) begin
      for (int a = 0; a < 4; a++) begin
        run_cycle(1'b1, 3'(k), addrs[a], addrs[a][7:0] ^ 8'(k * 17), 8'(8'h80 + k * 4 + a));
      end
    end
    for (int k = 1; k < 6; k++) begin
      run_cycle(1'b1, 3'(k), 16'h12FF, 8'hE7, 8'h42);
      run_cycle(1'b1, 3'(6 - k), 16'h3400, 8'h18, 8'h24);
    end
    // R11: request with req_i low gives an idle cycle
    run_cycle(1'b0, 3'd1, 16'h5555, 8'h00, 8'h99);
    run_cycle(1'b0, 3'd0, 16'h0000, 8'h00, 8'h66);
    run_cycle(1'b0, 3'd0, 16'h0000, 8'h00, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule